// File: doc/BRIEF.md
# Modular Compress/Decompress Unit

This unit converts lattice-KEM polynomial coefficients between the residue range 0..3328 (modulus q = 3329) and short d-bit symbols, as ciphertext encoding and decoding need. One request per cycle enters on a valid-qualified input bus. A one-bit mode selects compression (coefficient to symbol) or decompression (symbol to coefficient), and a four-bit width field picks d between 1 and 12 for that request alone. Requests can arrive back to back with any mix of modes and widths.

Compression needs a quotient by q. The unit never divides. It multiplies the dividend by the constant 5039 and keeps the bits above position 24. That estimate can fall short by one, so a single remainder comparison corrects it. Every constant product is built from shifted copies of its operand that are added together, so it maps to general logic and never to a hard multiplier. Results are registered, so each answer appears exactly one clock after its request.

Top module: `cdq_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock. While `rst_n` is low, `out_valid` and `out_value` are 0.
- R2: With `in_mode` = 0 (compress) and a width d in 1..12, a coefficient x in 0..3328 gives `out_value` = floor((x·2^d + 1664) / 3329) mod 2^d on the next clock.
- R3: With `in_mode` = 1 (decompress) and d in 1..12, a symbol y gives `out_value` = ((y mod 2^d)·3329 + 2^(d-1)) >> d on the next clock. The result is always below 3329.
- R4: A compress request with d = 1 returns 1 exactly when 832 < x <= 2496, and returns 0 otherwise (for example, 832 gives 0, 833 gives 1, 2496 gives 1 and 2497 gives 0).
- R5: A decompress request with d = 1 returns 1665 for a symbol of 1 and 0 for a symbol of 0.
- R6: For a decompress request, input bits at position d and above have no effect on the result.
- R7: A width code outside 1..12 (that is, 0, 13, 14 or 15) in a valid request gives `out_value` = 0, in either mode.
- R8: In a cycle with `in_valid` low, `out_value` keeps its previous value on the next clock.
- R9: Compression wraps modulo 2^d. A coefficient near q whose rounded quotient equals 2^d gives 0 (for example, x = 3328 with d = 4 gives 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 1 | 0 = compress, 1 = decompress |
| in_width | input | 4 | Symbol width d, legal range 1..12 |
| in_value | input | 12 | Coefficient (compress) or symbol (decompress) |
| out_valid | output | 1 | Result present this cycle |
| out_value | output | 12 | Symbol (compress) or coefficient (decompress) |

## Verification
The single result register can take a new request in the same cycle that the previous result leaves it. A compress answer can therefore be replaced by a decompress answer of a different width, or by the zero that an illegal width produces, with no idle cycle between them. The bench provokes this by issuing back-to-back requests that alternate mode and width on every clock. It also issues an illegal-width request directly after a request with a nonzero result. Each output sample is judged against the integer-division model of its own request only, so any carry-over from the neighbouring request shows up as a mismatch.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

    // Field modulus and rounding offset
    localparam int unsigned Q           = 3329;
    localparam int unsigned HALF_Q      = (Q - 1) / 2;

    // Coefficient / symbol geometry
    localparam int unsigned COEF_W      = 12;
    localparam int unsigned DMAX        = 12;
    localparam int unsigned WIDTH_W     = $clog2(DMAX + 1);

    // Reciprocal approximation of 1/Q
    localparam int unsigned RECIP       = 5039;
    localparam int unsigned RECIP_SHIFT = 24;

    // Derived widths
    localparam int unsigned Q_W         = $clog2(Q + 1);
    localparam int unsigned RECIP_W     = $clog2(RECIP + 1);
    localparam int unsigned DIV_W       = COEF_W + DMAX;
    localparam int unsigned QE_W        = DIV_W + RECIP_W - RECIP_SHIFT;
    localparam int unsigned REM_W       = QE_W + Q_W;

    typedef enum logic {
        MODE_COMPRESS   = 1'b0,
        MODE_DECOMPRESS = 1'b1
    } cdq_mode_e;

    typedef struct packed {
        logic              valid;
        logic [COEF_W-1:0] value;
    } cdq_result_t;

endpackage

// File: rtl/cdq_const_mul.sv
// Multiply by a fixed constant using shifted partial terms summed in logic.
module cdq_const_mul #(
    parameter int unsigned IN_W    = 12,
    parameter int unsigned CONST_W = 12,
    parameter int unsigned CONST   = 1,
    localparam int unsigned OUT_W  = IN_W + CONST_W
) (
    input  logic [IN_W-1:0]  a,
    output logic [OUT_W-1:0] p
);

    logic [OUT_W-1:0] term [CONST_W];
    logic [OUT_W-1:0] acc;

    for (genvar i = 0; i < CONST_W; i++) begin : g_term
        if (((CONST >> i) & 1) != 0) begin : g_on
            assign term[i] = OUT_W'(a) << i;
        end else begin : g_off
            assign term[i] = '0;
        end
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < CONST_W; i++) begin
            acc = acc + term[i];
        end
    end

    assign p = acc;

endmodule

// File: rtl/cdq_compress.sv
// Rounded scaling x -> round(x * 2^d / Q) mod 2^d, with no divider.
module cdq_compress
    import cdq_pkg::*;
(
    input  logic [COEF_W-1:0]  x,
    input  logic [WIDTH_W-1:0] d,
    output logic [COEF_W-1:0]  sym
);

    logic [DIV_W-1:0]           dividend;
    logic [DIV_W+RECIP_W-1:0]   scaled;
    logic [QE_W-1:0]            q_est;
    logic [REM_W-1:0]           q_back;
    logic [REM_W-1:0]           rem;
    logic [QE_W-1:0]            q_fix;
    logic [QE_W-1:0]            mask;

    // Dividend carries the half-modulus offset for round-half-up
    assign dividend = (DIV_W'(x) << d) + DIV_W'(HALF_Q);

    // Quotient estimate: dividend * RECIP >> RECIP_SHIFT
    cdq_const_mul #(
        .IN_W    (DIV_W),
        .CONST_W (RECIP_W),
        .CONST   (RECIP)
    ) u_recip_mul (
        .a (dividend),
        .p (scaled)
    );

    assign q_est = QE_W'(scaled >> RECIP_SHIFT);

    // Multiply the estimate back by Q to form the remainder
    cdq_const_mul #(
        .IN_W    (QE_W),
        .CONST_W (Q_W),
        .CONST   (Q)
    ) u_back_mul (
        .a (q_est),
        .p (q_back)
    );

    always_comb begin
        rem   = REM_W'(dividend) - q_back;
        q_fix = (rem >= REM_W'(Q)) ? (q_est + QE_W'(1)) : q_est;
        mask  = (QE_W'(1) << d) - QE_W'(1);
        sym   = COEF_W'(q_fix & mask);
    end

endmodule

// File: rtl/cdq_decompress.sv
// Rounded expansion y -> round(y * Q / 2^d).
module cdq_decompress
    import cdq_pkg::*;
(
    input  logic [COEF_W-1:0]  y,
    input  logic [WIDTH_W-1:0] d,
    output logic [COEF_W-1:0]  coef
);

    localparam int unsigned PROD_W = COEF_W + Q_W;
    localparam int unsigned SUM_W  = PROD_W + 1;

    logic [COEF_W:0]     mask_wide;
    logic [COEF_W-1:0]   y_m;
    logic [PROD_W-1:0]   prod;
    logic [SUM_W-1:0]    rnd;
    logic [SUM_W-1:0]    sum;

    assign mask_wide = ((COEF_W + 1)'(1) << d) - (COEF_W + 1)'(1);
    assign y_m       = y & COEF_W'(mask_wide);

    cdq_const_mul #(
        .IN_W    (COEF_W),
        .CONST_W (Q_W),
        .CONST   (Q)
    ) u_q_mul (
        .a (y_m),
        .p (prod)
    );

    always_comb begin
        rnd  = SUM_W'(1) << (d - WIDTH_W'(1));
        sum  = SUM_W'(prod) + rnd;
        coef = COEF_W'(sum >> d);
    end

endmodule

// File: rtl/cdq_unit.sv
// Compress/decompress unit with one registered stage.
module cdq_unit
    import cdq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_mode,
    input  logic [WIDTH_W-1:0] in_width,
    input  logic [COEF_W-1:0]  in_value,
    output logic               out_valid,
    output logic [COEF_W-1:0]  out_value
);

    cdq_result_t       res_d, res_q;
    logic [COEF_W-1:0] cmp_sym;
    logic [COEF_W-1:0] dec_coef;
    logic              width_ok;
    cdq_mode_e         mode;

    cdq_compress u_compress (
        .x   (in_value),
        .d   (in_width),
        .sym (cmp_sym)
    );

    cdq_decompress u_decompress (
        .y    (in_value),
        .d    (in_width),
        .coef (dec_coef)
    );

    assign mode     = cdq_mode_e'(in_mode);
    assign width_ok = (in_width >= WIDTH_W'(1)) && (in_width <= WIDTH_W'(DMAX));

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            if (!width_ok) begin
                res_d.value = '0;
            end else if (mode == MODE_DECOMPRESS) begin
                res_d.value = dec_coef;
            end else begin
                res_d.value = cmp_sym;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_value = res_q.value;

endmodule

// File: rtl/cdq_unit_chk.sv
module cdq_unit_chk
    import cdq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_mode,
    input logic [WIDTH_W-1:0] in_width,
    input logic [COEF_W-1:0]  in_value,
    input logic               out_valid,
    input logic [COEF_W-1:0]  out_value
);

    logic legal;
    assign legal = (in_width >= WIDTH_W'(1)) && (in_width <= WIDTH_W'(DMAX));

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    cmp_fits_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && legal) |=> ((out_value >> $past(in_width)) == '0));

    // R3
    dec_below_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode && legal) |=> (out_value < COEF_W'(Q)));

    // R4
    d1_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && in_width == WIDTH_W'(1)) |=>
        (out_value == (($past(in_value) > COEF_W'(832) && $past(in_value) <= COEF_W'(2496))
                       ? COEF_W'(1) : COEF_W'(0))));

    // R5
    d1_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode && in_width == WIDTH_W'(1)) |=>
        (out_value == ($past(in_value[0]) ? COEF_W'(1665) : COEF_W'(0))));

    // R7
    bad_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legal) |=> (out_value == '0));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_value));

endmodule

bind cdq_unit cdq_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_width  (in_width),
    .in_value  (in_value),
    .out_valid (out_valid),
    .out_value (out_value)
);

// File: tb/cdq_unit_test.sv
module cdq_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q_REF      = 3329;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_mode;
    logic [3:0]  in_width;
    logic [11:0] in_value;
    logic        out_valid;
    logic [11:0] out_value;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cdq_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_width  (in_width),
        .in_value  (in_value),
        .out_valid (out_valid),
        .out_value (out_value)
    );

    function automatic int ref_compress(int x, int d);
        if (d < 1 || d > 12) return 0;
        return (((x << d) + (Q_REF - 1) / 2) / Q_REF) % (1 << d);
    endfunction

    function automatic int ref_decompress(int y, int d);
        if (d < 1 || d > 12) return 0;
        return (((y & ((1 << d) - 1)) * Q_REF) + (1 << (d - 1))) >> d;
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a request at a falling edge; return at the next falling edge,
    // after the result register has captured it.
    task automatic issue(input logic mode, input int w, input int v);
        in_valid = 1'b1;
        in_mode  = mode;
        in_width = 4'(w);
        in_value = 12'(v);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic t_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_mode  = 1'b0;
        in_width = 4'd0;
        in_value = 12'd0;
        repeat (3) @(negedge clk);
        check_eq("R1 reset out_valid", int'(out_valid), 0);
        check_eq("R1 reset out_value", int'(out_value), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_latency();
        in_valid = 1'b0;
        @(negedge clk);
        check_eq("R1 idle gives no valid", int'(out_valid), 0);
        issue(1'b1, 1, 1);
        check_eq("R1 valid after one clock", int'(out_valid), 1);
        check_eq("R1 value after one clock", int'(out_value), 1665);
        in_valid = 1'b0;
        @(negedge clk);
        check_eq("R1 valid drops after one clock", int'(out_valid), 0);
    endtask

    task automatic t_compress_sweep();
        for (int d = 1; d <= 12; d++) begin
            for (int x = 0; x < Q_REF; x++) begin
                issue(1'b0, d, x);
                check_eq("R2 compress", int'(out_value), ref_compress(x, d));
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_decompress_sweep();
        for (int d = 1; d <= 12; d++) begin
            for (int y = 0; y < (1 << d); y++) begin
                issue(1'b1, d, y);
                check_eq("R3 decompress", int'(out_value), ref_decompress(y, d));
                if (int'(out_value) >= Q_REF)
                    check_eq("R3 decompress below q", int'(out_value), Q_REF - 1);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_d1_edges();
        issue(1'b0, 1, 832);  check_eq("R4 x=832",  int'(out_value), 0);
        issue(1'b0, 1, 833);  check_eq("R4 x=833",  int'(out_value), 1);
        issue(1'b0, 1, 2496); check_eq("R4 x=2496", int'(out_value), 1);
        issue(1'b0, 1, 2497); check_eq("R4 x=2497", int'(out_value), 0);
        issue(1'b0, 1, 0);    check_eq("R4 x=0",    int'(out_value), 0);
        issue(1'b1, 1, 1);    check_eq("R5 y=1",    int'(out_value), 1665);
        issue(1'b1, 1, 0);    check_eq("R5 y=0",    int'(out_value), 0);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_upper_bits();
        // Only the low d bits of the symbol count
        issue(1'b1, 4, 12'hAB5);
        check_eq("R6 d=4 high bits set", int'(out_value), 1040);
        issue(1'b1, 10, 12'hC01);
        check_eq("R6 d=10 high bits set", int'(out_value), ref_decompress(1, 10));
        issue(1'b1, 1, 12'hFFE);
        check_eq("R6 d=1 high bits set", int'(out_value), 0);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_illegal_width();
        int bad[4] = '{0, 13, 14, 15};
        foreach (bad[i]) begin
            issue(1'b1, 1, 1);
            check_eq("R7 preload nonzero", int'(out_value), 1665);
            issue(1'(i % 2), bad[i], 1234);
            check_eq("R7 illegal width gives zero", int'(out_value), 0);
            check_eq("R7 illegal width still valid", int'(out_valid), 1);
        end
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_hold();
        issue(1'b0, 10, 2000);
        check_eq("R8 setup", int'(out_value), ref_compress(2000, 10));
        in_valid = 1'b0;
        in_mode  = 1'b1;
        in_width = 4'd5;
        in_value = 12'd7;
        @(negedge clk);
        check_eq("R8 held after idle", int'(out_value), ref_compress(2000, 10));
        in_value = 12'd3000;
        @(negedge clk);
        check_eq("R8 held after second idle", int'(out_value), ref_compress(2000, 10));
    endtask

    task automatic t_wrap();
        issue(1'b0, 4, 3328);
        check_eq("R9 x=3328 d=4 wraps", int'(out_value), 0);
        issue(1'b0, 12, 3328);
        check_eq("R9 x=3328 d=12", int'(out_value), 4095);
        issue(1'b0, 5, 3300);
        check_eq("R9 x=3300 d=5 wraps", int'(out_value), ref_compress(3300, 5));
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_interleave();
        int widths[6] = '{1, 4, 5, 10, 11, 12};
        for (int k = 0; k < 60; k++) begin
            int w;
            int v;
            w = widths[k % 6];
            if ((k % 2) == 0) begin
                v = (k * 577 + 13) % Q_REF;
                issue(1'b0, w, v);
                check_eq("R1 interleave compress", int'(out_value), ref_compress(v, w));
            end else begin
                v = (k * 733 + 5) % 4096;
                issue(1'b1, w, v);
                check_eq("R1 interleave decompress", int'(out_value), ref_decompress(v, w));
            end
            check_eq("R1 interleave valid", int'(out_valid), 1);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check_eq("R1 interleave tail", int'(out_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_latency();
        t_d1_edges();
        t_upper_bits();
        t_illegal_width();
        t_hold();
        t_wrap();
        t_interleave();
        t_compress_sweep();
        t_decompress_sweep();
        finish_run();
    end

endmodule